// File: doc/BRIEF.md
# Three-Table Configurable Logic Cell

The cell is one tile of a programmable logic fabric. It has two 4-input lookup tables, called the F table and the G table. A third, 3-input table, called the H table, merges the F result and the G result with one extra input. Two select bits choose what drives each combinational output. The X output shows either the F result or the H result. The Y output shows either the G result or the H result. A pair of flip-flops registers X and Y onto the outputs XQ and YQ. The flip-flops have a shared clock enable and a synchronous clear.

All table contents and select bits sit in one 42-bit serial chain. The chain advances by one bit on each clock while the configuration enable is high. The bit leaving the end of the chain is brought out, so several cells can be strung into one longer chain. While the chain is loading, the flip-flops are frozen. This means a reconfiguration cannot disturb registered state.

Top module: `cfg_logic_cell`

## Requirements
- R1: The F result is bit `a` of the F table, where `a = f_in` (f_in[3] is the most significant address bit). The F table occupies configuration bits 15:0, with bit i holding the entry for address i.
- R2: The G result is bit `a` of the G table, where `a = g_in` (g_in[3] is the most significant bit). The G table occupies configuration bits 31:16, with bit 16+i holding the entry for address i.
- R3: The H result is the H table entry at address {F result, G result, h_in}, with the F result as bit 2 and h_in as bit 0. The H table occupies configuration bits 39:32.
- R4: Configuration bit 40 selects the source of x: 1 selects the F result, 0 selects the H result. Configuration bit 41 selects the source of y: 1 selects the G result, 0 selects the H result.
- R5: On each rising clock edge with cfg_en high, cfg_din enters at bit 41 and every other bit moves one place down. After 42 such edges, the first bit shifted in sits at bit 0. With cfg_en low, the configuration does not change.
- R6: cfg_dout always equals configuration bit 0, which is the bit that leaves the chain on the next shift.
- R7: When cfg_en is low and ff_clr is high, xq and yq are 0 after the next rising edge, whatever the value of ff_ce.
- R8: When cfg_en is low, ff_clr is low and ff_ce is high, xq and yq take the values x and y had before the edge.
- R9: When cfg_en, ff_clr and ff_ce are all low, xq and yq keep their values.
- R10: While cfg_en is high, xq and yq keep their values, whatever ff_ce and ff_clr are doing.
- R11: While rst_n is low, the configuration and both flip-flops are cleared at once. As a result, x, y, xq, yq and cfg_dout all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift the configuration chain; freeze the flip-flops |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (chain bit 0) |
| f_in | input | 4 | F table address |
| g_in | input | 4 | G table address |
| h_in | input | 1 | Extra H table input |
| ff_ce | input | 1 | Flip-flop clock enable |
| ff_clr | input | 1 | Synchronous flip-flop clear |
| x | output | 1 | Combinational output X |
| y | output | 1 | Combinational output Y |
| xq | output | 1 | Registered X |
| yq | output | 1 | Registered Y |

## Verification
The bench loads the cell with a three-variable function of A, B and C, where F4 is a don't-care, together with Y = A·B'. It then sweeps every address of both tables. This exposes a table placed at the wrong chain offset, or an address wired in reverse order.

A second configuration routes X through an H table that is deliberately not symmetric. This catches a design that swaps the order of the F result, the G result and h_in in the H address.

The bench also reloads the chain while toggling the clock enable and the clear. A cell that let the flip-flops capture during loading, or let the clear win over the freeze, would show a changed xq or yq.

A patterned load observes cfg_dout on every shift. This catches an off-by-one chain length or a wrong shift direction.

// File: rtl/cfg_cell_pkg.sv
package cfg_cell_pkg;
    localparam int LUT_K    = 4;                 // inputs of F and G tables
    localparam int HLUT_K   = 3;                 // inputs of H table
    localparam int LUT_SZ   = 1 << LUT_K;
    localparam int HLUT_SZ  = 1 << HLUT_K;
    localparam int SEL_BITS = 2;
    localparam int CFG_W    = 2 * LUT_SZ + HLUT_SZ + SEL_BITS;

    // Packed so that f_tab lands on the least significant chain bits.
    typedef struct packed {
        logic                 y_sel;
        logic                 x_sel;
        logic [HLUT_SZ-1:0]   h_tab;
        logic [LUT_SZ-1:0]    g_tab;
        logic [LUT_SZ-1:0]    f_tab;
    } cell_cfg_t;

    typedef struct packed {
        logic xq;
        logic yq;
    } ff_state_t;
endpackage

// File: rtl/cell_lut.sv
module cell_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tab,
    input  logic [K-1:0]      addr,
    output logic              o
);
    always_comb begin
        o = tab[addr];
    end
endmodule

// File: rtl/cell_cfg_chain.sv
module cell_cfg_chain
    import cfg_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_en,
    input  logic      cfg_din,
    output cell_cfg_t cfg,
    output logic      cfg_dout
);
    logic [CFG_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (cfg_en) begin
            chain_d = {cfg_din, chain_q[CFG_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign cfg      = cell_cfg_t'(chain_q);
    assign cfg_dout = chain_q[0];

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> chain_q[CFG_W-1] == $past(cfg_din));                 // R5
    AST_CFG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(chain_q));                                  // R5
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> chain_q[CFG_W-2:0] == $past(chain_q[CFG_W-1:1]));     // R5
endmodule

// File: rtl/cell_out_reg.sv
module cell_out_reg
    import cfg_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic clr,
    input  logic ce,
    input  logic x_in,
    input  logic y_in,
    output logic xq,
    output logic yq
);
    ff_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!freeze) begin
            if (clr)     st_d = '0;
            else if (ce) st_d = '{xq: x_in, yq: y_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xq = st_q.xq;
    assign yq = st_q.yq;

    AST_FF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(st_q));                                      // R10
    AST_FF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && clr) |=> (xq == 1'b0 && yq == 1'b0));               // R7
    AST_FF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !clr && !ce) |=> $stable(st_q));                    // R9
    AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !clr && ce) |=> (xq == $past(x_in) && yq == $past(y_in))); // R8
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import cfg_cell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_din,
    output logic              cfg_dout,
    input  logic [LUT_K-1:0]  f_in,
    input  logic [LUT_K-1:0]  g_in,
    input  logic              h_in,
    input  logic              ff_ce,
    input  logic              ff_clr,
    output logic              x,
    output logic              y,
    output logic              xq,
    output logic              yq
);
    cell_cfg_t         cfg;
    logic              f_res, g_res, h_res;
    logic [HLUT_K-1:0] h_addr;

    cell_cfg_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg      (cfg),
        .cfg_dout (cfg_dout)
    );

    cell_lut #(.K(LUT_K)) u_flut (.tab(cfg.f_tab), .addr(f_in), .o(f_res));
    cell_lut #(.K(LUT_K)) u_glut (.tab(cfg.g_tab), .addr(g_in), .o(g_res));

    // F result is the most significant H address bit.
    assign h_addr = {f_res, g_res, h_in};
    cell_lut #(.K(HLUT_K)) u_hlut (.tab(cfg.h_tab), .addr(h_addr), .o(h_res));

    always_comb begin
        x = cfg.x_sel ? f_res : h_res;
        y = cfg.y_sel ? g_res : h_res;
    end

    cell_out_reg u_ff (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (cfg_en),
        .clr    (ff_clr),
        .ce     (ff_ce),
        .x_in   (x),
        .y_in   (y),
        .xq     (xq),
        .yq     (yq)
    );

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |-> (xq == 1'b0 && yq == 1'b0 && cfg_dout == 1'b0));    // R11
endmodule

// File: tb/cfg_logic_cell_tb.sv
module cfg_logic_cell_tb_top;
    localparam int W = 42;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_en, cfg_din, cfg_dout;
    logic [3:0] f_in, g_in;
    logic h_in, ff_ce, ff_clr;
    logic x, y, xq, yq;

    always #5 clk = ~clk;   // 100 MHz

    cfg_logic_cell dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .f_in(f_in), .g_in(g_in), .h_in(h_in),
        .ff_ce(ff_ce), .ff_clr(ff_clr), .x(x), .y(y), .xq(xq), .yq(yq)
    );

    typedef struct {
        logic  ex, ey, exq, eyq, edout;
        string tag;
    } exp_t;

    exp_t   sb_q[$];
    event   ev_chk;
    int     n_chk  = 0;
    int     n_fail = 0;
    logic [W-1:0] sh = '0;      // bench view of the configuration
    logic   m_xq = 1'b0, m_yq = 1'b0;
    bit     done = 1'b0;

    function automatic logic mdl_x(logic [W-1:0] c, logic [3:0] f, logic [3:0] g, logic h);
        logic fr, gr, hr;
        fr = c[f];
        gr = c[16 + g];
        hr = c[32 + {fr, gr, h}];
        return c[40] ? fr : hr;
    endfunction

    function automatic logic mdl_y(logic [W-1:0] c, logic [3:0] f, logic [3:0] g, logic h);
        logic fr, gr, hr;
        fr = c[f];
        gr = c[16 + g];
        hr = c[32 + {fr, gr, h}];
        return c[41] ? gr : hr;
    endfunction

    // Monitor: pops expectations and compares with the ports.
    initial begin
        forever begin
            @(ev_chk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if ({x, y, xq, yq, cfg_dout} !== {e.ex, e.ey, e.exq, e.eyq, e.edout}) begin
                    n_fail++;
                    $display("FAIL %s: x,y,xq,yq,dout actual=%b%b%b%b%b expected=%b%b%b%b%b",
                             e.tag, x, y, xq, yq, cfg_dout,
                             e.ex, e.ey, e.exq, e.eyq, e.edout);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, one expectation.
    task automatic step(input logic [3:0] f, input logic [3:0] g, input logic h,
                        input logic ce, input logic clr, input logic en,
                        input logic din, input string tag);
        exp_t e;
        @(negedge clk);
        f_in = f; g_in = g; h_in = h; ff_ce = ce; ff_clr = clr;
        cfg_en = en; cfg_din = din;
        #1;
        e.ex = mdl_x(sh, f, g, h);
        e.ey = mdl_y(sh, f, g, h);
        e.exq = m_xq; e.eyq = m_yq; e.edout = sh[0];
        e.tag = tag;
        sb_q.push_back(e);
        -> ev_chk;
        @(posedge clk);
        if (en) sh = {din, sh[W-1:1]};
        else if (clr) begin m_xq = 1'b0; m_yq = 1'b0; end
        else if (ce) begin m_xq = e.ex; m_yq = e.ey; end
    endtask

    task automatic load_cfg(input logic [W-1:0] v, input string tag);
        for (int i = 0; i < W; i++)
            step(4'(i), 4'(i * 3), i[0], i[1], i[2], 1'b1, v[i], tag);
    endtask

    task automatic direct_zero_check(input string tag);
        n_chk++;
        if ({x, y, xq, yq, cfg_dout} !== 5'b0) begin
            n_fail++;
            $display("FAIL %s: x,y,xq,yq,dout actual=%b%b%b%b%b expected=00000",
                     tag, x, y, xq, yq, cfg_dout);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] cfg_a, cfg_b, cfg_c;
        // A=f[0], B=f[1], C=f[2], F4 don't-care: X = A.B'.C + A'.B.C'
        cfg_a = '0;
        for (int a = 0; a < 16; a++) begin
            cfg_a[a]      = (a[0] & ~a[1] & a[2]) | (~a[0] & a[1] & ~a[2]);
            cfg_a[16 + a] = a[0] & ~a[1];            // Y = A.B'
        end
        cfg_a[39:32] = 8'hB4;
        cfg_a[40] = 1'b1; cfg_a[41] = 1'b1;
        cfg_b = cfg_a;
        cfg_b[40] = 1'b0;                            // X from H
        cfg_c = 42'h2A5_5AA3_C3F0;

        rst_n = 1'b0; cfg_en = 0; cfg_din = 0; f_in = 0; g_in = 0;
        h_in = 0; ff_ce = 0; ff_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        direct_zero_check("R11 reset state");
        rst_n = 1'b1;

        step(4'hF, 4'hF, 1, 1, 0, 0, 0, "R11 R8 empty config");
        load_cfg(cfg_a, "R5 R6 R10 load A");
        for (int a = 0; a < 16; a++)
            step(4'(a), 4'(a), a[0], 0, 0, 0, 0, "R1 R2 R4 R9 sweep A");
        for (int a = 0; a < 16; a++)
            step(4'(15 - a), 4'(a), 0, 1, 0, 0, 0, "R8 capture");
        step(4'h5, 4'h1, 0, 1, 0, 0, 0, "R8 set ones");
        step(4'h5, 4'h1, 0, 1, 1, 0, 0, "R7 clear over ce");
        step(4'h5, 4'h1, 0, 1, 0, 0, 0, "R8 set again");
        step(4'h0, 4'h0, 0, 0, 0, 0, 0, "R9 hold");
        load_cfg(cfg_b, "R5 R10 load B frozen");
        for (int a = 0; a < 32; a++)
            step(4'(a >> 1), 4'((a * 5) >> 1), a[0], 1, 0, 0, 0, "R3 R4 H path");
        load_cfg(cfg_c, "R5 R6 chain out");
        load_cfg(42'h0, "R5 R6 flush pattern");
        step(4'h3, 4'h3, 1, 1, 0, 0, 0, "R5 steady");

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        direct_zero_check("R11 async reset");
        #2;
        while (sb_q.size() > 0) #1;
        done = 1'b1;
        finish_run();
    end
endmodule